// File: doc/BRIEF.md
# Queued SPI Transfer Controller

This block is an SPI master that works through a list of transfers held in an internal queue. The host needs to step in only to load entries and to start or stop the run. Each queue entry holds a transmit word, the index of the peripheral select to drive, a bit count and the number of idle cycles to insert after the transfer. The sequencer fetches the entries one at a time. For each entry it asserts the chosen select, shifts the word out in SPI mode 0 (clock idles low, data sampled on the rising edge), stores the received bits in a receive slot with the same index and then waits the programmed gap.

A run starts at entry 0 and finishes after the entry named by the end pointer. The end pointer and the wrap flag are captured when the run starts. With wrap set, the sequencer returns to entry 0 after the end entry and keeps going, so a set of converters or sensors can be polled with no host attention. A stop request takes effect once the current transfer and its gap have finished. The host can read the receive slots at any time through a read port with a single cycle of latency.

Top module: `qspiq_ctrl`

## Requirements
- R1: After synchronous reset, every select line is high, the serial clock is low, and both busy and done are low.
- R2: A transfer drives the serial clock from a low idle level, with each high and low phase lasting SCK_HALF clock cycles. The data line is valid at each rising edge. The low bits of the entry's data word are sent most significant bit first.
- R3: The controller samples miso on each rising serial clock edge. The received bits are stored right-aligned, with the upper bits zero, in the receive slot of the entry that was just executed. rx_data returns slot rx_idx one clock after rx_idx is applied.
- R4: A length code from 1 to 16 produces exactly that many serial clock pulses. A code of 0, or any code above 16, produces 16 pulses.
- R5: The 2-bit select field value s drives ss_n[s] low for the whole transfer. No more than one select line is low at any time.
- R6: Between two consecutive transfers, all select lines stay high for exactly dly+3 clock cycles, where dly is the 8-bit delay field of the earlier entry.
- R7: A start issued while idle runs entries 0 through end_ptr in ascending order and clears done. With wrap off, done is set and busy falls once the end entry's gap has finished.
- R8: With wrap on, entry 0 follows the end entry with the normal gap, and the queue repeats until a stop is requested. done stays low in this mode.
- R9: A stop issued during a transfer lets that transfer and its gap finish. After that, no further transfer starts, busy falls and done stays low.
- R10: A start pulse issued while busy has no effect: the run in progress continues and visits each entry exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_we | input | 1 | Write one queue entry |
| ent_idx | input | IDX_W | Entry index to write |
| ent_data | input | DATA_W | Transmit word |
| ent_sel | input | SEL_W | Select line index |
| ent_len | input | LEN_W | Bit count code (0 means full width) |
| ent_dly | input | DLY_W | Idle cycles after the transfer |
| end_ptr | input | IDX_W | Last entry of a run, captured at start |
| wrap_en | input | 1 | Repeat the queue, captured at start |
| start | input | 1 | Begin a run when idle |
| stop | input | 1 | Stop at the next entry boundary |
| rx_idx | input | IDX_W | Receive slot to read |
| rx_data | output | DATA_W | Receive slot contents, one cycle latency |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A non-wrapping run reached its end entry |
| cur_idx | output | IDX_W | Entry being executed |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSEL | Active-low peripheral selects |

## Verification
The bench builds the block with a four-entry queue and SCK_HALF=1. With this configuration every transfer takes only a few dozen cycles. The bench therefore sweeps all 32 values of the 5-bit length code, including 0 and the codes above 16, and checks each one for pulse count, transmitted bits, select line and received word. The short queue also makes wrap cycles brief, so several trips around entries 0 to 2 run before a stop. A model of the peripheral in the bench sends a different word for each transfer and records the gap before each select falls, so the bench also checks the delay field (including a long value of 200), the ordering, the stop boundary and the start pulse that must be ignored.

// File: rtl/qspiq_pkg.sv
package qspiq_pkg;

  typedef enum logic [2:0] {
    Q_IDLE  = 3'd0,
    Q_FETCH = 3'd1,
    Q_LOAD  = 3'd2,
    Q_RUN   = 3'd3,
    Q_GAP   = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_LOW  = 2'd1,
    SH_HIGH = 2'd2
  } shf_state_t;

endpackage

// File: rtl/qspiq_dpram.sv
module qspiq_dpram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/qspiq_shifter.sv
module qspiq_shifter
  import qspiq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 5,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              fin
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int HC_W  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  shf_state_t        state;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  left;
  logic [HC_W-1:0]   ph;
  logic [CNT_W-1:0]  eff_len;
  logic              ph_last;

  // Code 0 or an out-of-range code selects the full word.
  always_comb begin
    if (len_code == '0 || int'(len_code) > DATA_W) eff_len = CNT_W'(DATA_W);
    else                                           eff_len = CNT_W'(len_code);
  end

  assign ph_last = (ph == HC_W'(SCK_HALF - 1));
  assign mosi    = sr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SH_IDLE;
      sclk    <= 1'b0;
      sr      <= '0;
      rx_word <= '0;
      left    <= '0;
      ph      <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (state)
        SH_IDLE: begin
          if (go) begin
            sr      <= tx_word << (CNT_W'(DATA_W) - eff_len);
            rx_word <= '0;
            left    <= eff_len;
            ph      <= '0;
            state   <= SH_LOW;
          end
        end
        SH_LOW: begin
          if (ph_last) begin
            ph      <= '0;
            sclk    <= 1'b1;
            rx_word <= {rx_word[DATA_W-2:0], miso};
            state   <= SH_HIGH;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SH_HIGH: begin
          if (ph_last) begin
            ph   <= '0;
            sclk <= 1'b0;
            sr   <= sr << 1;
            left <= left - 1'b1;
            if (left == CNT_W'(1)) begin
              state <= SH_IDLE;
              fin   <= 1'b1;
            end else begin
              state <= SH_LOW;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  // R4: a shift in progress always has bits remaining
  a_r4_bits_remaining: assert property (@(posedge clk) disable iff (rst)
    (state != SH_IDLE) |-> (left != '0));

  // R2: the serial clock rests low whenever no shift is active
  a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    (state == SH_IDLE) |-> !sclk);

endmodule

// File: rtl/qspiq_sequencer.sv
module qspiq_sequencer
  import qspiq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int NSEL   = 4,
  parameter int DLY_W  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SEL_W = (NSEL > 1) ? $clog2(NSEL) : 1,
  localparam int LEN_W = $clog2(DATA_W) + 1,
  localparam int ENT_W = DATA_W + SEL_W + LEN_W + DLY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              wrap_en,
  input  logic [IDX_W-1:0]  end_ptr,
  output logic [IDX_W-1:0]  cmd_raddr,
  input  logic [ENT_W-1:0]  cmd_rdata,
  output logic              sh_go,
  output logic [DATA_W-1:0] sh_tx,
  output logic [LEN_W-1:0]  sh_len,
  input  logic              sh_fin,
  input  logic [DATA_W-1:0] sh_rx,
  output logic              rx_we,
  output logic [IDX_W-1:0]  rx_waddr,
  output logic [DATA_W-1:0] rx_wdata,
  output logic [NSEL-1:0]   ss_n,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  cur_idx
);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  end_q;
  logic              wrap_q;
  logic              stop_pend;
  logic [DLY_W-1:0]  dly_q;
  logic [DLY_W-1:0]  cnt;

  logic [DATA_W-1:0] e_data;
  logic [SEL_W-1:0]  e_sel;
  logic [LEN_W-1:0]  e_len;
  logic [DLY_W-1:0]  e_dly;

  assign e_data = cmd_rdata[DATA_W-1:0];
  assign e_sel  = cmd_rdata[DATA_W +: SEL_W];
  assign e_len  = cmd_rdata[DATA_W+SEL_W +: LEN_W];
  assign e_dly  = cmd_rdata[DATA_W+SEL_W+LEN_W +: DLY_W];

  assign cmd_raddr = idx;
  assign rx_waddr  = idx;
  assign cur_idx   = idx;
  assign busy      = (state != Q_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= Q_IDLE;
      idx       <= '0;
      end_q     <= '0;
      wrap_q    <= 1'b0;
      stop_pend <= 1'b0;
      dly_q     <= '0;
      cnt       <= '0;
      sh_go     <= 1'b0;
      sh_tx     <= '0;
      sh_len    <= '0;
      rx_we     <= 1'b0;
      rx_wdata  <= '0;
      ss_n      <= '1;
      done      <= 1'b0;
    end else begin
      sh_go <= 1'b0;
      rx_we <= 1'b0;
      if (stop && state != Q_IDLE) stop_pend <= 1'b1;
      case (state)
        Q_IDLE: begin
          if (start) begin
            idx       <= '0;
            end_q     <= end_ptr;
            wrap_q    <= wrap_en;
            done      <= 1'b0;
            stop_pend <= 1'b0;
            state     <= Q_FETCH;
          end
        end
        Q_FETCH: state <= Q_LOAD;
        Q_LOAD: begin
          sh_tx <= e_data;
          sh_len <= e_len;
          sh_go <= 1'b1;
          dly_q <= e_dly;
          ss_n  <= ~(NSEL'(1) << e_sel);
          state <= Q_RUN;
        end
        Q_RUN: begin
          if (sh_fin) begin
            rx_we    <= 1'b1;
            rx_wdata <= sh_rx;
            ss_n     <= '1;
            cnt      <= dly_q;
            state    <= Q_GAP;
          end
        end
        Q_GAP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (idx == end_q) begin
            if (wrap_q && !stop_pend) begin
              idx   <= '0;
              state <= Q_FETCH;
            end else begin
              done  <= !wrap_q;
              state <= Q_IDLE;
            end
          end else if (stop_pend) begin
            state <= Q_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= Q_FETCH;
          end
        end
        default: state <= Q_IDLE;
      endcase
    end
  end

  // R5: no two peripherals selected together
  a_r5_single_select: assert property (@(posedge clk) disable iff (rst)
    $countones(~ss_n) <= 1);

  // R3: a receive slot is written only right after the shifter finished
  a_r3_write_follows_shift: assert property (@(posedge clk) disable iff (rst)
    rx_we |-> $past(sh_fin));

  // R7: completion is flagged only as the run goes idle
  a_r7_done_at_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (state == Q_IDLE));

  // R8: returning from the end entry to a fetch happens only in wrap mode
  a_r8_wrap_only: assert property (@(posedge clk) disable iff (rst)
    (state == Q_FETCH && $past(state) == Q_GAP && $past(idx) == $past(end_q))
      |-> wrap_q);

  // R2: the shifter is launched only with a select asserted
  a_r2_go_with_select: assert property (@(posedge clk) disable iff (rst)
    sh_go |-> (ss_n != '1));

endmodule

// File: rtl/qspiq_ctrl.sv
module qspiq_ctrl #(
  parameter int DEPTH    = 16,
  parameter int DATA_W   = 16,
  parameter int NSEL     = 4,
  parameter int DLY_W    = 8,
  parameter int SCK_HALF = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SEL_W = (NSEL > 1) ? $clog2(NSEL) : 1,
  localparam int LEN_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [DATA_W-1:0] ent_data,
  input  logic [SEL_W-1:0]  ent_sel,
  input  logic [LEN_W-1:0]  ent_len,
  input  logic [DLY_W-1:0]  ent_dly,
  input  logic [IDX_W-1:0]  end_ptr,
  input  logic              wrap_en,
  input  logic              start,
  input  logic              stop,
  input  logic [IDX_W-1:0]  rx_idx,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NSEL-1:0]   ss_n
);

  localparam int ENT_W = DATA_W + SEL_W + LEN_W + DLY_W;

  logic [IDX_W-1:0]  cmd_raddr;
  logic [ENT_W-1:0]  cmd_rdata;
  logic              sh_go;
  logic [DATA_W-1:0] sh_tx;
  logic [LEN_W-1:0]  sh_len;
  logic              sh_fin;
  logic [DATA_W-1:0] sh_rx;
  logic              rx_we;
  logic [IDX_W-1:0]  rx_waddr;
  logic [DATA_W-1:0] rx_wdata;

  qspiq_dpram #(.DEPTH(DEPTH), .WIDTH(ENT_W)) cmd_mem_i (
    .clk   (clk),
    .we    (ent_we),
    .waddr (ent_idx),
    .wdata ({ent_dly, ent_len, ent_sel, ent_data}),
    .raddr (cmd_raddr),
    .rdata (cmd_rdata)
  );

  qspiq_dpram #(.DEPTH(DEPTH), .WIDTH(DATA_W)) rx_mem_i (
    .clk   (clk),
    .we    (rx_we),
    .waddr (rx_waddr),
    .wdata (rx_wdata),
    .raddr (rx_idx),
    .rdata (rx_data)
  );

  qspiq_sequencer #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .NSEL(NSEL), .DLY_W(DLY_W)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop      (stop),
    .wrap_en   (wrap_en),
    .end_ptr   (end_ptr),
    .cmd_raddr (cmd_raddr),
    .cmd_rdata (cmd_rdata),
    .sh_go     (sh_go),
    .sh_tx     (sh_tx),
    .sh_len    (sh_len),
    .sh_fin    (sh_fin),
    .sh_rx     (sh_rx),
    .rx_we     (rx_we),
    .rx_waddr  (rx_waddr),
    .rx_wdata  (rx_wdata),
    .ss_n      (ss_n),
    .busy      (busy),
    .done      (done),
    .cur_idx   (cur_idx)
  );

  qspiq_shifter #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .SCK_HALF(SCK_HALF)
  ) shf_i (
    .clk      (clk),
    .rst      (rst),
    .go       (sh_go),
    .tx_word  (sh_tx),
    .len_code (sh_len),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .rx_word  (sh_rx),
    .fin      (sh_fin)
  );

  // R2: the serial clock pulses only while a peripheral is selected
  a_r2_clock_inside_select: assert property (@(posedge clk) disable iff (rst)
    sclk |-> (ss_n != '1));

endmodule

// File: tb/qspiq_ctrl_tb_top.sv
module qspiq_ctrl_tb_top;

  localparam int DEPTH = 4;
  localparam int DW    = 16;
  localparam int NSEL  = 4;
  localparam int DLYW  = 8;
  localparam int HALF  = 1;
  localparam int IW    = 2;
  localparam int SW    = 2;
  localparam int LW    = 5;
  localparam int LOGN  = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, ent_we, wrap_en, start, stop, busy, done, sclk, mosi, miso;
  logic [IW-1:0] ent_idx, end_ptr, rx_idx, cur_idx;
  logic [DW-1:0] ent_data, rx_data;
  logic [SW-1:0] ent_sel;
  logic [LW-1:0] ent_len;
  logic [DLYW-1:0] ent_dly;
  logic [NSEL-1:0] ss_n;

  qspiq_ctrl #(.DEPTH(DEPTH), .DATA_W(DW), .NSEL(NSEL), .DLY_W(DLYW), .SCK_HALF(HALF)) dut_i (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_idx(ent_idx), .ent_data(ent_data),
    .ent_sel(ent_sel), .ent_len(ent_len), .ent_dly(ent_dly), .end_ptr(end_ptr),
    .wrap_en(wrap_en), .start(start), .stop(stop), .rx_idx(rx_idx), .rx_data(rx_data),
    .busy(busy), .done(done), .cur_idx(cur_idx), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] rsp_of(input int k);
    logic [31:0] t;
    t = (k + 1) * 32'd40503;
    return t[15:0] ^ 16'h5A3C;
  endfunction

  function automatic int eff_of(input int lc);
    return (lc == 0 || lc > 16) ? 16 : lc;
  endfunction

  function automatic int mask_of(input int e);
    return (e >= 16) ? 32'hFFFF : ((1 << e) - 1);
  endfunction

  // peripheral model and monitor
  logic ss_idle;
  assign ss_idle = &ss_n;
  logic mon_on = 1'b0;
  logic [15:0] slv_sr;
  logic [15:0] cap;
  int nbits, xfer_n, gap_cnt, cur_sel;
  int log_cap [LOGN];
  int log_nb  [LOGN];
  int log_sel [LOGN];
  int log_gap [LOGN];

  initial begin
    miso = 1'b0; xfer_n = 0; gap_cnt = 0; nbits = 0; cap = '0; slv_sr = '0; cur_sel = 0;
  end

  always @(negedge clk) begin
    if (ss_idle) gap_cnt++;
    else gap_cnt = 0;
  end

  always @(negedge ss_idle) begin
    if (mon_on) begin
      slv_sr = rsp_of(xfer_n);
      miso = slv_sr[15];
      cap = '0;
      nbits = 0;
      cur_sel = -1;
      for (int i = NSEL - 1; i >= 0; i--) if (!ss_n[i]) cur_sel = i;
      if (xfer_n < LOGN) log_gap[xfer_n] = gap_cnt;
    end
  end

  always @(negedge sclk) begin
    if (mon_on && !ss_idle) begin
      slv_sr = slv_sr << 1;
      miso = slv_sr[15];
    end
  end

  always @(posedge sclk) begin
    if (mon_on) begin
      cap = {cap[14:0], mosi};
      nbits++;
    end
  end

  always @(posedge ss_idle) begin
    if (mon_on && xfer_n < LOGN) begin
      log_cap[xfer_n] = cap;
      log_nb[xfer_n]  = nbits;
      log_sel[xfer_n] = cur_sel;
      xfer_n++;
    end
  end

  int tb_data [DEPTH];
  int tb_sel  [DEPTH];
  int tb_len  [DEPTH];
  int tb_dly  [DEPTH];

  task automatic load(input int i, input int d, input int s, input int l, input int g);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = IW'(i); ent_data = DW'(d); ent_sel = SW'(s);
    ent_len = LW'(l); ent_dly = DLYW'(g);
    tb_data[i] = d; tb_sel[i] = s; tb_len[i] = l; tb_dly[i] = g;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic go(input int e, input logic w);
    @(negedge clk);
    end_ptr = IW'(e); wrap_en = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk("R7 run ends", int'(busy), 0);
  endtask

  task automatic wait_xfers(input int target);
    int n = 0;
    while (xfer_n < target && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_select();
    int n = 0;
    while (ss_idle && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic read_rx(input int i, output int v);
    @(negedge clk);
    rx_idx = IW'(i);
    @(negedge clk);
    v = int'(rx_data);
  endtask

  task automatic chk_xfer(input int k, input int i);
    int e;
    e = eff_of(tb_len[i]);
    chk("R4 pulse count", log_nb[k], e);
    chk("R2 tx bits", log_cap[k], tb_data[i] & mask_of(e));
    chk("R5 select", log_sel[k], tb_sel[i]);
  endtask

  initial begin
    int base, v, n0;
    rst = 1'b1; ent_we = 1'b0; ent_idx = '0; ent_data = '0; ent_sel = '0; ent_len = '0;
    ent_dly = '0; end_ptr = '0; wrap_en = 1'b0; start = 1'b0; stop = 1'b0; rx_idx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 selects", int'(ss_n), 32'hF);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);

    // Four-entry run, no wrap: R2 R3 R4 R5 R6 R7
    load(0, 32'hC3A5, 0, 16, 0);
    load(1, 32'h0015, 1, 5, 3);
    load(2, 32'h0001, 2, 1, 200);
    load(3, 32'h8001, 3, 0, 1);
    base = xfer_n;
    go(3, 1'b0);
    chk("R7 busy after start", int'(busy), 1);
    wait_idle();
    chk("R7 transfer count", xfer_n - base, 4);
    chk("R7 done set", int'(done), 1);
    for (int k = 0; k < 4; k++) begin
      chk_xfer(base + k, k);
      if (k > 0) chk("R6 gap", log_gap[base + k], tb_dly[k - 1] + 3);
      read_rx(k, v);
      chk("R3 rx slot", v, int'(rsp_of(base + k) >> (16 - eff_of(tb_len[k]))));
    end

    // R10 start while busy is ignored; R7 done cleared on new start
    base = xfer_n;
    go(3, 1'b0);
    chk("R7 done cleared", int'(done), 0);
    wait_xfers(base + 1);
    @(negedge clk);
    end_ptr = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R10 transfer count", xfer_n - base, 4);
    for (int k = 0; k < 4; k++) chk("R10 order", log_sel[base + k], tb_sel[k]);

    // Exhaustive length code sweep: R4 R2 R3 R5
    for (int lc = 0; lc < 32; lc++) begin
      load(0, (32'hB2E7 ^ (lc * 32'h1357)) & 32'hFFFF, lc % 4, lc, 0);
      base = xfer_n;
      go(0, 1'b0);
      wait_idle();
      chk("R4 one transfer", xfer_n - base, 1);
      chk_xfer(base, 0);
      read_rx(0, v);
      chk("R3 rx sweep", v, int'(rsp_of(base) >> (16 - eff_of(lc))));
    end

    // Wrap mode: R8, then stop: R9
    load(0, 32'h1234, 3, 4, 0);
    load(1, 32'h00AB, 1, 8, 2);
    load(2, 32'h0F0F, 0, 12, 5);
    base = xfer_n;
    go(2, 1'b1);
    wait_xfers(base + 7);
    wait_select();
    pulse_stop();
    wait_idle();
    chk("R9 stop after current", xfer_n - base, 8);
    chk("R8 R9 done low", int'(done), 0);
    for (int k = 0; k < 8; k++) chk_xfer(base + k, k % 3);
    chk("R8 gap at wrap", log_gap[base + 3], tb_dly[2] + 3);
    n0 = xfer_n;
    repeat (60) @(negedge clk);
    chk("R9 no more transfers", xfer_n, n0);
    chk("R9 selects idle", int'(ss_n), 32'hF);

    // Stop during first transfer of a non-wrapping run: R9
    load(3, 32'h0055, 2, 7, 0);
    base = xfer_n;
    go(3, 1'b0);
    wait_select();
    pulse_stop();
    wait_idle();
    chk("R9 single transfer", xfer_n - base, 1);
    chk("R9 done low", int'(done), 0);
    chk_xfer(base, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule